// File: doc/BRIEF.md
# Register-Mapped 1-Wire Bus Host

This block is a host controller for a single-wire, open-drain serial bus. It drives the bus through a small 32-bit register file. Software writes an instruction word, which holds an opcode in bits 11:8 and an operand in bits 7:0, and then sets a go bit. The engine then runs one of five operations: a bus reset with a presence check, a single-bit write, a single-bit read, an eight-bit write or an eight-bit read. During the operation it produces the timed low pulses on the line. It samples the line at fixed points of each slot. The result goes to the status register or the data register.

The engine reports two states separately. Ready means a new instruction may be launched. Done means the launched instruction has finished. Software polls either flag, or it arms a level interrupt through an enable register. The line is only ever pulled low or released, and the pull-up lives outside the block. All slot timing comes from a microsecond tick. That tick is derived from a clocks-per-microsecond parameter.

Top module: `owire_host`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0x00000010: ready (bit 4) is set, done (bit 0) and the absence flag (bit 31) are clear. The data register (0x10) reads 0, `irq` is low and the line is released.
- R2: Offset 0x18 reads the major version 1 in bits 23:8 and `MINOR_VER` in bits 7:0, with the other bits zero. Offset 0x1C reads `ID_WORD`.
- R3: Writing 1 to control bit 0 (offset 0x04) launches the instruction stored at 0x00 while ready is set. Ready clears while the instruction is in flight. Done sets when it completes and stays set, with no relaunch, while go stays 1. Writing 0 to control clears done and restores ready.
- R4: Opcode 0x8 holds the line low for 480 µs and samples it 70 µs after release. Status bit 31 then gives that level: 1 means no device answered and 0 means a device is present.
- R5: Opcode 0xE writes operand bit 0 and opcode 0xF writes the operand byte least significant bit first. Each bit uses a 70 µs slot, with 6 µs low for a 1 and 60 µs low for a 0.
- R6: Opcode 0xC drives a 6 µs low pulse, samples the line 15 µs into the slot and returns the level in data bit 0. Opcode 0xD runs eight such slots and assembles data bits 7:0 least significant bit first.
- R7: Interrupt enable (0x08) bit 0 selects done and bit 4 selects ready. `irq` is a registered level equal to the OR of the enabled flags. With both enable bits zero, `irq` is low.
- R8: Control bit 31 is a soft reset. While it is set the engine is aborted, the line is released within two cycles, ready reads 1 and done reads 0, and go launches nothing.
- R9: An opcode other than 0x8, 0xC, 0xD, 0xE or 0xF completes with done set and produces no low pulse on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered one cycle after `reg_addr` |
| irq | output | 1 | Level interrupt request |
| ow_drive_low | output | 1 | 1 pulls the bus line low, 0 releases it |
| ow_in | input | 1 | Bus line level as seen at the pad |

## Verification
A behavioural bus device measures every low pulse the host drives. It answers a long pulse with a presence pulse when it is enabled, and it holds the line low through the sample point of a read slot to return a zero. Write bytes are a directed 0xA5 plus random values. The slave logs their slot widths, which separates a wrong bit order or a wrong low length from a correct transfer. Read bytes are a directed 0x3C plus random values, and they expose a wrong sample point or a shift direction error. Reset is run with and without a device, to tell the two absence levels apart. Further cases hold go after done, abort with the soft reset in mid-pulse, issue an unknown opcode and walk the interrupt through each enable pattern. These cases separate the handshake and the interrupt rules from the slot engine itself.

// File: rtl/owh_pkg.sv
package owh_pkg;

  localparam logic [4:0] A_INSTR = 5'h00;
  localparam logic [4:0] A_CTRL  = 5'h04;
  localparam logic [4:0] A_IRQE  = 5'h08;
  localparam logic [4:0] A_STAT  = 5'h0C;
  localparam logic [4:0] A_DATA  = 5'h10;
  localparam logic [4:0] A_VER   = 5'h18;
  localparam logic [4:0] A_ID    = 5'h1C;

  localparam int B_DONE   = 0;
  localparam int B_READY  = 4;
  localparam int B_ABSENT = 31;
  localparam int B_GO     = 0;
  localparam int B_SRST   = 31;

  typedef enum logic [3:0] {
    OPC_RESET  = 4'h8,
    OPC_RDBIT  = 4'hC,
    OPC_RDBYTE = 4'hD,
    OPC_WRBIT  = 4'hE,
    OPC_WRBYTE = 4'hF
  } opc_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_FIN} eng_st_e;

  typedef struct packed {
    logic valid;
    logic is_rst;
    logic is_rd;
    logic is_byte;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [3:0] code);
    op_dec_t d;
    d = '0;
    case (code)
      OPC_RESET:  begin d.valid = 1'b1; d.is_rst = 1'b1; end
      OPC_RDBIT:  begin d.valid = 1'b1; d.is_rd = 1'b1; end
      OPC_RDBYTE: begin d.valid = 1'b1; d.is_rd = 1'b1; d.is_byte = 1'b1; end
      OPC_WRBIT:  begin d.valid = 1'b1; end
      OPC_WRBYTE: begin d.valid = 1'b1; d.is_byte = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/owh_tick.sv
module owh_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_pass;
      assign unused_pass = clk ^ rst ^ clr;
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/owh_sync.sv
module owh_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end
  assign q = sh[STAGES-1];
endmodule

// File: rtl/owh_engine.sv
module owh_engine
  import owh_pkg::*;
#(
  parameter int T_RST_LOW  = 480,
  parameter int T_PRES_SMP = 70,
  parameter int T_RST_WIN  = 480,
  parameter int T_SHORT    = 6,
  parameter int T_LONG     = 60,
  parameter int T_RD_SMP   = 15,
  parameter int T_SLOT     = 70
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        abort,
  input  logic        tick,
  input  logic        start,
  input  logic [11:0] instr,
  input  logic        line_in,
  output logic        bus_low,
  output logic        active,
  output logic        fin,
  output logic        rx_upd,
  output logic [7:0]  rx_byte,
  output logic        pres_upd,
  output logic        pres_absent
);
  localparam int US_W = $clog2(T_RST_LOW + T_RST_WIN + 1);
  localparam logic [US_W-1:0] C_RST_LOW = US_W'(T_RST_LOW);
  localparam logic [US_W-1:0] C_RST_SMP = US_W'(T_RST_LOW + T_PRES_SMP);
  localparam logic [US_W-1:0] C_RST_END = US_W'(T_RST_LOW + T_RST_WIN);
  localparam logic [US_W-1:0] C_SHORT   = US_W'(T_SHORT);
  localparam logic [US_W-1:0] C_LONG    = US_W'(T_LONG);
  localparam logic [US_W-1:0] C_RD_SMP  = US_W'(T_RD_SMP);
  localparam logic [US_W-1:0] C_SLOT    = US_W'(T_SLOT);

  eng_st_e         st;
  logic [US_W-1:0] t;
  logic [7:0]      sr;
  logic [2:0]      left;
  logic            m_rst, m_rd, m_byte;
  logic            bus_q, fin_q, rx_upd_q, pres_upd_q, pres_q;
  logic [7:0]      rx_q;
  logic [US_W-1:0] low_len, smp_at, end_at;
  logic            has_smp;
  op_dec_t         dec;

  assign dec = decode_op(instr[11:8]);

  // slot shape for the bit currently in flight
  always_comb begin
    has_smp = m_rst | m_rd;
    if (m_rst) begin
      low_len = C_RST_LOW; smp_at = C_RST_SMP; end_at = C_RST_END;
    end else if (m_rd) begin
      low_len = C_SHORT;   smp_at = C_RD_SMP;  end_at = C_SLOT;
    end else begin
      low_len = sr[0] ? C_SHORT : C_LONG;
      smp_at  = '0;
      end_at  = C_SLOT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st <= ST_IDLE; t <= '0; sr <= '0; left <= '0;
      m_rst <= 1'b0; m_rd <= 1'b0; m_byte <= 1'b0;
      bus_q <= 1'b0; fin_q <= 1'b0; rx_upd_q <= 1'b0; pres_upd_q <= 1'b0;
      rx_q <= '0; pres_q <= 1'b0;
    end else begin
      fin_q      <= 1'b0;
      rx_upd_q   <= 1'b0;
      pres_upd_q <= 1'b0;
      bus_q      <= (st == ST_SLOT) && (t < low_len);
      case (st)
        ST_IDLE: if (start) begin
          t      <= '0;
          m_rst  <= dec.is_rst;
          m_rd   <= dec.is_rd;
          m_byte <= dec.is_byte;
          left   <= dec.is_byte ? 3'd7 : 3'd0;
          sr     <= dec.is_byte ? instr[7:0] : {7'b0, instr[0]};
          st     <= dec.valid ? ST_SLOT : ST_FIN;
        end
        ST_SLOT: if (tick) begin
          t <= t + 1'b1;
          if (has_smp && (t == smp_at - 1'b1)) begin
            if (m_rst) pres_q <= line_in;
            else       sr     <= {line_in, sr[7:1]};
          end
          if (t == end_at - 1'b1) begin
            if (left != 3'd0) begin
              left <= left - 1'b1;
              t    <= '0;
              if (!m_rd) sr <= {1'b0, sr[7:1]};
            end else begin
              st <= ST_FIN;
            end
          end
        end
        ST_FIN: begin
          st         <= ST_IDLE;
          fin_q      <= 1'b1;
          rx_upd_q   <= m_rd;
          pres_upd_q <= m_rst;
          if (m_rd) rx_q <= m_byte ? sr : {7'b0, sr[7]};
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_low     = bus_q;
  assign active      = (st != ST_IDLE);
  assign fin         = fin_q;
  assign rx_upd      = rx_upd_q;
  assign rx_byte     = rx_q;
  assign pres_upd    = pres_upd_q;
  assign pres_absent = pres_q;
endmodule

// File: rtl/owire_host.sv
module owire_host
  import owh_pkg::*;
#(
  parameter int          CLK_DIV     = 50,
  parameter int          SYNC_STAGES = 2,
  parameter int          T_RST_LOW   = 480,
  parameter int          T_PRES_SMP  = 70,
  parameter int          T_RST_WIN   = 480,
  parameter int          T_SHORT     = 6,
  parameter int          T_LONG      = 60,
  parameter int          T_RD_SMP    = 15,
  parameter int          T_SLOT      = 70,
  parameter logic [7:0]  MINOR_VER   = 8'h00,
  parameter logic [31:0] ID_WORD     = 32'h51A7_0E1D
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        ow_drive_low,
  input  logic        ow_in
);
  localparam logic [15:0] MAJOR_VER = 16'd1;

  logic [11:0] instr_q;
  logic        go_q, srst_q, en_done_q, en_ready_q;
  logic        busy_q, done_q, absent_q, irq_q;
  logic [7:0]  data_q;
  logic [31:0] rd_mux, rdata_q;
  logic        line_s, tick, launch;
  logic        eng_active, eng_fin, eng_rx_upd, eng_pres_upd, eng_absent;
  logic [7:0]  eng_rx;
  logic        unused_wbits;

  assign unused_wbits = ^reg_wdata[30:12];
  assign launch = go_q && !busy_q && !srst_q;

  owh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(ow_in), .q(line_s)
  );

  owh_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(launch), .tick(tick)
  );

  owh_engine #(
    .T_RST_LOW(T_RST_LOW), .T_PRES_SMP(T_PRES_SMP), .T_RST_WIN(T_RST_WIN),
    .T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_RD_SMP(T_RD_SMP), .T_SLOT(T_SLOT)
  ) u_eng (
    .clk(clk), .rst(rst), .abort(srst_q), .tick(tick), .start(launch),
    .instr(instr_q), .line_in(line_s), .bus_low(ow_drive_low),
    .active(eng_active), .fin(eng_fin), .rx_upd(eng_rx_upd), .rx_byte(eng_rx),
    .pres_upd(eng_pres_upd), .pres_absent(eng_absent)
  );

  // software-written registers
  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0; go_q <= 1'b0; srst_q <= 1'b0;
      en_done_q <= 1'b0; en_ready_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_INSTR: instr_q <= reg_wdata[11:0];
        A_CTRL: begin
          go_q   <= reg_wdata[B_GO];
          srst_q <= reg_wdata[B_SRST];
        end
        A_IRQE: begin
          en_done_q  <= reg_wdata[B_DONE];
          en_ready_q <= reg_wdata[B_READY];
        end
        default: ;
      endcase
    end
  end

  // launch / completion handshake
  always_ff @(posedge clk) begin
    if (rst || srst_q) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (launch)                                busy_q <= 1'b1;
      else if (!go_q && !eng_active && !eng_fin) busy_q <= 1'b0;
      if (!go_q)        done_q <= 1'b0;
      else if (eng_fin) done_q <= 1'b1;
    end
  end

  // results
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      absent_q <= 1'b0;
    end else begin
      if (eng_rx_upd)   data_q   <= eng_rx;
      if (eng_pres_upd) absent_q <= eng_absent;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (en_done_q & done_q) | (en_ready_q & !busy_q);
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_INSTR: rd_mux[11:0] = instr_q;
      A_CTRL: begin
        rd_mux[B_GO]   = go_q;
        rd_mux[B_SRST] = srst_q;
      end
      A_IRQE: begin
        rd_mux[B_DONE]  = en_done_q;
        rd_mux[B_READY] = en_ready_q;
      end
      A_STAT: begin
        rd_mux[B_DONE]   = done_q;
        rd_mux[B_READY]  = !busy_q;
        rd_mux[B_ABSENT] = absent_q;
      end
      A_DATA:  rd_mux[7:0] = data_q;
      A_VER:   rd_mux = {8'h00, MAJOR_VER, MINOR_VER};
      A_ID:    rd_mux = ID_WORD;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/owh_checker.sv
module owh_checker (
  input logic       clk,
  input logic       rst,
  input logic       go,
  input logic       srst,
  input logic       busy,
  input logic       done,
  input logic [1:0] irq_en,
  input logic       irq,
  input logic       drive_low
);
  // R3: done is held while go stays set
  p_done_held_r3: assert property (@(posedge clk) disable iff (rst)
    (done && go && !srst) |=> done);

  // R3: status never shows ready and done together
  p_done_not_ready_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R7: with no enable bit set the request drops
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_en == 2'b00) |=> !irq);

  // R8: soft reset releases the line within two cycles
  p_srst_release_r8: assert property (@(posedge clk) disable iff (rst)
    srst |-> ##2 !drive_low);

  // R5: the line is only pulled while an instruction is in flight
  p_drive_in_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> $past(busy));
endmodule

bind owire_host owh_checker u_chk (
  .clk(clk), .rst(rst), .go(go_q), .srst(srst_q), .busy(busy_q),
  .done(done_q), .irq_en({en_ready_q, en_done_q}), .irq(irq),
  .drive_low(ow_drive_low)
);

// File: tb/sim_owire_host.sv
module sim_owire_host;
  import owh_pkg::*;

  localparam int DIV = 2;
  localparam logic [7:0]  MINOR = 8'h03;
  localparam logic [31:0] IDW   = 32'hC0DE_1F01;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        ow_drive_low;
  logic        dev_low;
  logic        ow_in;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;
  assign ow_in = !(ow_drive_low || dev_low);

  owire_host #(.CLK_DIV(DIV), .MINOR_VER(MINOR), .ID_WORD(IDW)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .ow_drive_low(ow_drive_low), .ow_in(ow_in)
  );

  // behavioural bus device
  bit       dev_present = 1'b1;
  bit       dev_rd_mode = 1'b0;
  logic [7:0] dev_tx  = 8'hFF;
  logic [7:0] dev_log = 8'h00;
  int       last_len = 0;
  int       n_falls  = 0;

  initial begin
    dev_low = 1'b0;
    forever begin
      @(negedge clk);
      if (ow_drive_low) begin
        int len;
        len = 0;
        while (ow_drive_low) begin
          len++;
          @(negedge clk);
        end
        last_len = len;
        n_falls++;
        if (len >= 400 * DIV) begin
          if (dev_present) begin
            repeat (20 * DIV) @(negedge clk);
            dev_low = 1'b1;
            repeat (100 * DIV) @(negedge clk);
            dev_low = 1'b0;
          end
        end else begin
          dev_log = {(len < 15 * DIV), dev_log[7:1]};
          if (dev_rd_mode) begin
            logic rb;
            rb = dev_tx[0];
            dev_tx = {1'b1, dev_tx[7:1]};
            if (!rb) begin
              dev_low = 1'b1;
              repeat (30 * DIV - len) @(negedge clk);
              dev_low = 1'b0;
            end
          end
        end
      end
    end
  end

  function automatic logic [31:0] exp_stat(bit done, bit ready, bit absent);
    return ({31'b0, done} << B_DONE) | ({31'b0, ready} << B_READY) |
           ({31'b0, absent} << B_ABSENT);
  endfunction

  function automatic int exp_low(bit b);
    return (b ? 6 : 60) * DIV;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = 32'h0;
    for (int i = 0; i < 20000 && !st[B_DONE]; i++) rd(A_STAT, st);
  endtask

  task automatic run_op(logic [31:0] ins, output logic [31:0] st, output logic [31:0] dat);
    logic [31:0] s2;
    wr(A_INSTR, ins);
    wr(A_CTRL, 32'h1);
    wait_done(st);
    rd(A_DATA, dat);
    chk(st[B_READY] == 1'b0 && st[B_DONE] == 1'b1, "R3 done set, ready low", st, exp_stat(1, 0, st[B_ABSENT]));
    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    rd(A_STAT, s2);
    chk((s2 & 32'h11) == 32'h10, "R3 go cleared restores ready", s2, 32'h10);
  endtask

  initial begin
    logic [31:0] v, st, dat;
    int f0;
    void'($urandom(32'd4711));
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(A_STAT, v);  chk(v == exp_stat(0, 1, 0), "R1 status after reset", v, exp_stat(0, 1, 0));
    rd(A_DATA, v);  chk(v == 32'h0, "R1 data after reset", v, 32'h0);
    chk(irq == 1'b0, "R1 irq low", {31'b0, irq}, 32'h0);
    chk(ow_drive_low == 1'b0, "R1 line released", {31'b0, ow_drive_low}, 32'h0);

    // R2 identification
    rd(A_VER, v);   chk(v == {8'h00, 16'd1, MINOR}, "R2 version", v, {8'h00, 16'd1, MINOR});
    rd(A_ID, v);    chk(v == IDW, "R2 id word", v, IDW);

    // R4 reset / presence
    dev_present = 1'b1;
    run_op(32'h0800, st, dat);
    chk(st[B_ABSENT] == 1'b0, "R4 device present", st, exp_stat(1, 0, 0));
    chk(last_len == 480 * DIV, "R4 reset low length", last_len, 480 * DIV);
    dev_present = 1'b0;
    run_op(32'h0800, st, dat);
    chk(st[B_ABSENT] == 1'b1, "R4 no device", st, exp_stat(1, 0, 1));
    dev_present = 1'b1;

    // R5 single bits
    for (int b = 0; b < 2; b++) begin
      run_op(32'h0E00 | b, st, dat);
      chk(last_len == exp_low(b[0]), "R5 write bit low length", last_len, exp_low(b[0]));
    end

    // R5 bytes: directed then random
    for (int k = 0; k < 5; k++) begin
      logic [7:0] by;
      by = (k == 0) ? 8'hA5 : 8'($urandom);
      f0 = n_falls;
      run_op(32'h0F00 | {24'h0, by}, st, dat);
      chk(dev_log == by, "R5 write byte lsb first", {24'h0, dev_log}, {24'h0, by});
      chk(n_falls - f0 == 8, "R5 write byte slot count", n_falls - f0, 8);
    end

    // R6 read bit
    for (int b = 0; b < 2; b++) begin
      dev_tx = {7'h7F, b[0]}; dev_rd_mode = 1'b1;
      run_op(32'h0C00, st, dat);
      dev_rd_mode = 1'b0;
      chk(dat == {31'b0, b[0]}, "R6 read bit", dat, {31'b0, b[0]});
    end

    // R6 read byte: directed then random
    for (int k = 0; k < 5; k++) begin
      logic [7:0] by;
      by = (k == 0) ? 8'h3C : 8'($urandom);
      dev_tx = by; dev_rd_mode = 1'b1;
      run_op(32'h0D00, st, dat);
      dev_rd_mode = 1'b0;
      chk(dat == {24'h0, by}, "R6 read byte", dat, {24'h0, by});
    end

    // R3 ready drops while running, no relaunch while go is held
    wr(A_INSTR, 32'h0E01);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_STAT, v);
    chk(v == exp_stat(0, 0, 1), "R3 busy while running", v, exp_stat(0, 0, 1));
    wait_done(st);
    f0 = n_falls;
    repeat (400) @(negedge clk);
    rd(A_STAT, v);
    chk(v == exp_stat(1, 0, 1), "R3 done held with go", v, exp_stat(1, 0, 1));
    chk(n_falls == f0, "R3 no relaunch", n_falls, f0);
    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);

    // R7 interrupt
    wr(A_IRQE, 32'h10);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R7 ready irq", {31'b0, irq}, 32'h1);
    wr(A_IRQE, 32'h0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R7 enable zero drops irq", {31'b0, irq}, 32'h0);
    wr(A_IRQE, 32'h01);
    wr(A_INSTR, 32'h0E01);
    wr(A_CTRL, 32'h1);
    repeat (5) @(negedge clk);
    chk(irq == 1'b0, "R7 no done irq while running", {31'b0, irq}, 32'h0);
    wait_done(st);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R7 done irq", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R7 done irq clears with go", {31'b0, irq}, 32'h0);
    wr(A_IRQE, 32'h0);

    // R8 soft reset in the middle of a reset pulse
    wr(A_INSTR, 32'h0800);
    wr(A_CTRL, 32'h1);
    repeat (100) @(negedge clk);
    chk(ow_drive_low == 1'b1, "R8 line low before abort", {31'b0, ow_drive_low}, 32'h1);
    wr(A_CTRL, 32'h8000_0001);
    repeat (3) @(negedge clk);
    chk(ow_drive_low == 1'b0, "R8 line released by soft reset", {31'b0, ow_drive_low}, 32'h0);
    f0 = n_falls;
    repeat (100) @(negedge clk);
    rd(A_STAT, v);
    chk((v & 32'h11) == 32'h10, "R8 ready, not done", v, 32'h10);
    chk(n_falls == f0, "R8 go ignored while held", n_falls, f0);
    wr(A_CTRL, 32'h0);
    run_op(32'h0E00, st, dat);
    chk(last_len == exp_low(1'b0), "R8 engine usable after abort", last_len, exp_low(1'b0));

    // R9 unknown opcode
    f0 = n_falls;
    run_op(32'h0300, st, dat);
    chk(n_falls == f0, "R9 no pulse for unknown opcode", n_falls, f0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule